// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM. It takes the memory from power-on to a state where it can accept normal traffic. After reset it holds the command pins at NOP and keeps clock-enable and the data mask high. It waits out a power-on pause whose length in clocks comes from the clock frequency and the pause time. It then precharges every bank, and runs a burst of auto-refresh commands and one mode register load in the order a configuration bit selects. When the last wait has expired it raises `init_done`. From then on the command pins stay at NOP until another controller block takes over.

All waits use one shared down-counter: the power-on pause, the precharge recovery tRP, the refresh cycle tRFC and the mode-load delay tMRD. Each command state loads the counter. The wait state that follows leaves when the counter reports that one clock is left.

The states are `S_PAUSE`, `S_PRECHARGE`, `S_WAIT_RP`, `S_REFRESH`, `S_WAIT_RFC`, `S_LOAD_MODE`, `S_WAIT_MRD` and `S_READY`. The transitions are:
- PAUSE→PRECHARGE when the pause expires.
- PRECHARGE→WAIT_RP.
- WAIT_RP→REFRESH if refreshes come first, otherwise WAIT_RP→LOAD_MODE.
- REFRESH→WAIT_RFC.
- WAIT_RFC→REFRESH while refreshes are still owed. Otherwise WAIT_RFC→LOAD_MODE if the mode is not yet loaded, and WAIT_RFC→READY if it is.
- LOAD_MODE→WAIT_MRD.
- WAIT_MRD→REFRESH while refreshes are owed, otherwise WAIT_MRD→READY.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: From reset until `init_done`, `sd_dqm` is 1. For the first PAUSE_CLKS = CLK_MHZ*PAUSE_US cycles after reset release (cycles 0..PAUSE_CLKS-1), the command pins {cs_n,ras_n,cas_n,we_n} read 4'b0111 (NOP). The same holds while reset is held.
- R2: In cycle PAUSE_CLKS the block issues precharge-all: pins 4'b0010 with `sd_addr[10]` = 1.
- R3: The command after the precharge comes exactly T_RP cycles after it, with NOP in every cycle between.
- R4: With `cfg_ref_first` = 1, all refreshes come between the precharge and the mode load. With 0, the mode load follows the precharge wait directly and all refreshes come after it.
- R5: Auto-refresh (pins 4'b0001) is issued max(`cfg_ref_num`, MIN_REF) times. Consecutive commands after a refresh are exactly T_RFC cycles apart, with NOP between.
- R6: The mode load is pins 4'b0000. In that cycle `sd_addr` equals `cfg_mode` zero-extended and `sd_ba` is 0. It comes only after the precharge.
- R7: The command or ready point after the mode load comes exactly T_MRD cycles later, with NOP between.
- R8: `init_done` rises exactly one wait period (T_RFC or T_MRD) after the last command and then stays high. While it is high, the pins are NOP and `sd_dqm` is 0.
- R9: Each sequence issues exactly one precharge and one mode load. The pins only ever carry NOP, precharge, refresh or mode load, so no activate, read or write is issued.
- R10: `sd_cke` is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts the sequence |
| cfg_mode | input | MODE_W | Value loaded into the mode register |
| cfg_ref_first | input | 1 | 1: refreshes before the mode load; 0: after |
| cfg_ref_num | input | REF_W | Requested refresh count (raised to MIN_REF if lower) |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | 1 | Data mask, high until ready |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_addr | output | ADDR_W | Address bus (precharge-all bit, mode value) |
| sd_ba | output | BANK_W | Bank address |
| init_done | output | 1 | Sequence complete |

## Verification
The bench builds the block with CLK_MHZ=2 and PAUSE_US=10, which gives a 20-cycle pause. It uses T_RP=3, T_RFC=5, T_MRD=2, MIN_REF=8 and REF_W=4. With these values a whole sequence fits in about a hundred cycles, so many sequences fit in one run. The exact cycle of every command is predicted and compared in each run, for both refresh orderings. The refresh counts cover the clamped values (0 and 7 become 8), the exact minimum of 8 and the maximum of 15. T_MRD=2 exercises the shortest wait the counter handles, where the wait state lasts a single cycle.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Command pins packed as {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        S_PAUSE,
        S_PRECHARGE,
        S_WAIT_RP,
        S_REFRESH,
        S_WAIT_RFC,
        S_LOAD_MODE,
        S_WAIT_MRD,
        S_READY
    } init_state_e;

    // Address bit that widens a precharge to every bank
    localparam int ALL_BANKS_BIT = 10;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last_tick
);

    logic [W-1:0] cnt_q;

    // Reset value is the power-on pause, so counting starts at release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // One clock left in the current wait
    assign last_tick = (cnt_q == W'(1));

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
    import sdram_init_pkg::*;
(
    input  sd_cmd_e cmd,
    output logic    cs_n,
    output logic    ras_n,
    output logic    cas_n,
    output logic    we_n
);

    always_comb begin
        cs_n  = cmd[3];
        ras_n = cmd[2];
        cas_n = cmd[1];
        we_n  = cmd[0];
    end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ  = 100,
    parameter int PAUSE_US = 200,
    parameter int T_RP     = 3,
    parameter int T_RFC    = 8,
    parameter int T_MRD    = 2,
    parameter int MIN_REF  = 8,
    parameter int REF_W    = 4,
    parameter int ADDR_W   = 13,
    parameter int MODE_W   = 12,
    parameter int BANK_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              cfg_ref_first,
    input  logic [REF_W-1:0]  cfg_ref_num,
    output logic              sd_cke,
    output logic              sd_dqm,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BANK_W-1:0] sd_ba,
    output logic              init_done
);

    localparam int PAUSE_CLKS = CLK_MHZ * PAUSE_US;
    localparam int MAX_WAIT   = (PAUSE_CLKS > T_RFC) ?
                                ((PAUSE_CLKS > T_RP) ? PAUSE_CLKS : T_RP) :
                                ((T_RFC > T_RP) ? T_RFC : T_RP);
    localparam int TMR_W      = $clog2(MAX_WAIT + 1);

    init_state_e state_q, state_d;
    sd_cmd_e     cmd;
    logic [REF_W-1:0] ref_cnt_q;
    logic [REF_W-1:0] ref_target;
    logic             refs_owed;
    logic             mode_loaded_q;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_last;

    // Refresh count is never below the minimum
    assign ref_target = (cfg_ref_num < REF_W'(MIN_REF)) ? REF_W'(MIN_REF) : cfg_ref_num;
    assign refs_owed  = (ref_cnt_q < ref_target);

    // Shared wait counter: each command state loads its own recovery time
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_PRECHARGE: begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_RP - 1);
            end
            S_REFRESH: begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_RFC - 1);
            end
            S_LOAD_MODE: begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_MRD - 1);
            end
            default: begin
                tmr_load = 1'b0;
                tmr_val  = '0;
            end
        endcase
    end

    sdram_init_timer #(
        .W       (TMR_W),
        .RST_VAL (PAUSE_CLKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tmr_load),
        .load_val  (tmr_val),
        .last_tick (tmr_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_PAUSE;
        end else begin
            state_q <= state_d;
        end
    end

    // Progress registers: refreshes issued, mode already loaded
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt_q     <= '0;
            mode_loaded_q <= 1'b0;
        end else begin
            if (state_q == S_REFRESH) begin
                ref_cnt_q <= ref_cnt_q + 1'b1;
            end
            if (state_q == S_LOAD_MODE) begin
                mode_loaded_q <= 1'b1;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_PAUSE: begin
                if (tmr_last) state_d = S_PRECHARGE;
            end
            S_PRECHARGE: state_d = S_WAIT_RP;
            S_WAIT_RP: begin
                if (tmr_last) state_d = cfg_ref_first ? S_REFRESH : S_LOAD_MODE;
            end
            S_REFRESH: state_d = S_WAIT_RFC;
            S_WAIT_RFC: begin
                if (tmr_last) begin
                    if (refs_owed)           state_d = S_REFRESH;
                    else if (!mode_loaded_q) state_d = S_LOAD_MODE;
                    else                     state_d = S_READY;
                end
            end
            S_LOAD_MODE: state_d = S_WAIT_MRD;
            S_WAIT_MRD: begin
                if (tmr_last) state_d = refs_owed ? S_REFRESH : S_READY;
            end
            S_READY: state_d = S_READY;
            default: state_d = S_PAUSE;
        endcase
    end

    // Outputs (Moore)
    always_comb begin
        cmd       = CMD_NOP;
        sd_addr   = '0;
        sd_ba     = '0;
        sd_cke    = 1'b1;
        sd_dqm    = 1'b1;
        init_done = 1'b0;
        unique case (state_q)
            S_PRECHARGE: begin
                cmd                    = CMD_PRE;
                sd_addr[ALL_BANKS_BIT] = 1'b1;
            end
            S_REFRESH: cmd = CMD_REF;
            S_LOAD_MODE: begin
                cmd     = CMD_MRS;
                sd_addr = ADDR_W'(cfg_mode);
            end
            S_READY: begin
                sd_dqm    = 1'b0;
                init_done = 1'b1;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    sdram_cmd_drive u_drive (
        .cmd   (cmd),
        .cs_n  (sd_cs_n),
        .ras_n (sd_ras_n),
        .cas_n (sd_cas_n),
        .we_n  (sd_we_n)
    );

endmodule

// File: rtl/sdram_pwrup_chk.sv
module sdram_pwrup_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              dqm,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);

    logic [3:0] pins;
    logic       is_nop, is_pre, is_ref, is_mrs;
    logic       seen_pre_q, seen_mrs_q;

    assign pins   = {cs_n, ras_n, cas_n, we_n};
    assign is_nop = (pins == 4'b0111);
    assign is_pre = (pins == 4'b0010);
    assign is_ref = (pins == 4'b0001);
    assign is_mrs = (pins == 4'b0000);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_pre_q <= 1'b0;
            seen_mrs_q <= 1'b0;
        end else begin
            if (is_pre) seen_pre_q <= 1'b1;
            if (is_mrs) seen_mrs_q <= 1'b1;
        end
    end

    p_cke_high_r10: assert property (@(posedge clk) disable iff (!rst_n) cke);

    p_legal_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_nop || is_pre || is_ref || is_mrs);

    p_single_pre_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> !seen_pre_q);

    p_single_mrs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> !seen_mrs_q);

    p_prech_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> addr[10]);

    p_mrs_after_pre_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> seen_pre_q);

    p_rp_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |=> is_nop);

    p_mrd_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |=> is_nop);

    p_dqm_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> dqm);

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (is_nop && !dqm && seen_mrs_q));

endmodule

bind sdram_pwrup_seq sdram_pwrup_chk #(.ADDR_W(ADDR_W)) u_pwrup_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (sd_cke),
    .dqm       (sd_dqm),
    .cs_n      (sd_cs_n),
    .ras_n     (sd_ras_n),
    .cas_n     (sd_cas_n),
    .we_n      (sd_we_n),
    .addr      (sd_addr),
    .init_done (init_done)
);

// File: tb/test_sdram_pwrup_seq.sv
module test_sdram_pwrup_seq;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 2;
    localparam int PAUSE_US   = 10;
    localparam int PAUSE_CLKS = CLK_MHZ * PAUSE_US;
    localparam int T_RP       = 3;
    localparam int T_RFC      = 5;
    localparam int T_MRD      = 2;
    localparam int MIN_REF    = 8;
    localparam int REF_W      = 4;
    localparam int ADDR_W     = 13;
    localparam int MODE_W     = 10;
    localparam int BANK_W     = 2;

    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_REF = 4'b0001;
    localparam logic [3:0] P_MRS = 4'b0000;

    logic              clk;
    logic              rst_n;
    logic [MODE_W-1:0] cfg_mode;
    logic              cfg_ref_first;
    logic [REF_W-1:0]  cfg_ref_num;
    logic              sd_cke, sd_dqm, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [ADDR_W-1:0] sd_addr;
    logic [BANK_W-1:0] sd_ba;
    logic              init_done;

    int n_vec;
    int n_bad;

    sdram_pwrup_seq #(
        .CLK_MHZ (CLK_MHZ), .PAUSE_US (PAUSE_US), .T_RP (T_RP), .T_RFC (T_RFC),
        .T_MRD (T_MRD), .MIN_REF (MIN_REF), .REF_W (REF_W), .ADDR_W (ADDR_W),
        .MODE_W (MODE_W), .BANK_W (BANK_W)
    ) i_sdram_pwrup_seq (
        .clk (clk), .rst_n (rst_n), .cfg_mode (cfg_mode),
        .cfg_ref_first (cfg_ref_first), .cfg_ref_num (cfg_ref_num),
        .sd_cke (sd_cke), .sd_dqm (sd_dqm), .sd_cs_n (sd_cs_n),
        .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n),
        .sd_addr (sd_addr), .sd_ba (sd_ba), .init_done (init_done)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    function automatic int eff_refs(input int req);
        return (req < MIN_REF) ? MIN_REF : req;
    endfunction

    task automatic run_seq(input logic [MODE_W-1:0] mode, input bit rf, input int rn);
        int st[24];
        logic [3:0] sc[24];
        int n_ev, t, tgt, done_t, ev;
        int n_pre, n_mrs, n_ref, ref_before;
        bit mrs_seen;
        logic [3:0] pins, exp_pins, last_cmd;
        string tag;

        tgt  = eff_refs(rn);
        n_ev = 0;
        t    = PAUSE_CLKS;
        st[n_ev] = t; sc[n_ev] = P_PRE; n_ev++; t += T_RP;
        if (rf) begin
            for (int i = 0; i < tgt; i++) begin
                st[n_ev] = t; sc[n_ev] = P_REF; n_ev++; t += T_RFC;
            end
            st[n_ev] = t; sc[n_ev] = P_MRS; n_ev++; t += T_MRD;
        end else begin
            st[n_ev] = t; sc[n_ev] = P_MRS; n_ev++; t += T_MRD;
            for (int i = 0; i < tgt; i++) begin
                st[n_ev] = t; sc[n_ev] = P_REF; n_ev++; t += T_RFC;
            end
        end
        done_t = t;

        @(negedge clk);
        cfg_mode      = mode;
        cfg_ref_first = rf;
        cfg_ref_num   = REF_W'(rn);
        rst_n         = 1'b0;
        #1;
        pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        check(pins == P_NOP, "R1", "pins in reset", pins, P_NOP);
        check(sd_dqm == 1'b1 && init_done == 1'b0, "R1", "dqm/done in reset",
              {sd_dqm, init_done}, 2'b10);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        ev = 0; n_pre = 0; n_mrs = 0; n_ref = 0; ref_before = 0;
        mrs_seen = 1'b0; last_cmd = P_NOP;
        for (int k = 0; k <= done_t + 4; k++) begin
            #1;
            pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (ev < n_ev && st[ev] == k) begin
                exp_pins = sc[ev];
                ev++;
            end else begin
                exp_pins = P_NOP;
            end
            if (exp_pins == P_PRE)      tag = "R2";
            else if (exp_pins == P_MRS) tag = "R6";
            else if (exp_pins == P_REF) tag = "R5";
            else if (k < PAUSE_CLKS)    tag = "R1";
            else if (k >= done_t)       tag = "R8";
            else if (last_cmd == P_PRE) tag = "R3";
            else if (last_cmd == P_MRS) tag = "R7";
            else                        tag = "R5";
            check(pins == exp_pins, tag, $sformatf("pins at cycle %0d", k), pins, exp_pins);
            if (exp_pins == P_PRE)
                check(sd_addr[10] == 1'b1, "R2", "precharge-all address bit", sd_addr[10], 1);
            if (exp_pins == P_MRS) begin
                check(sd_addr == ADDR_W'(mode), "R6", "mode value on address", sd_addr, mode);
                check(sd_ba == '0, "R6", "bank during mode load", sd_ba, 0);
            end
            check(init_done == (k >= done_t), "R8", $sformatf("init_done at cycle %0d", k),
                  init_done, (k >= done_t));
            check(sd_dqm == (k < done_t), (k < done_t) ? "R1" : "R8",
                  $sformatf("dqm at cycle %0d", k), sd_dqm, (k < done_t));
            check(sd_cke == 1'b1, "R10", "cke level", sd_cke, 1);
            if (exp_pins != P_NOP) last_cmd = exp_pins;
            if (pins == P_PRE) n_pre++;
            if (pins == P_MRS) begin n_mrs++; mrs_seen = 1'b1; end
            if (pins == P_REF) begin
                n_ref++;
                if (!mrs_seen) ref_before++;
            end
            @(negedge clk);
        end
        check(ref_before == (rf ? tgt : 0), "R4", "refreshes before mode load",
              ref_before, rf ? tgt : 0);
        check(n_ref == tgt, "R5", "refresh total", n_ref, tgt);
        check(n_pre == 1, "R9", "precharge count", n_pre, 1);
        check(n_mrs == 1, "R9", "mode load count", n_mrs, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL R8 watchdog: init_done actual=0 expected=1");
        finish_run();
    end

    initial begin
        n_vec         = 0;
        n_bad         = 0;
        rst_n         = 1'b0;
        cfg_mode      = '0;
        cfg_ref_first = 1'b1;
        cfg_ref_num   = '0;
        void'($urandom(32'h5eed_0042));

        // Directed corners: clamped, exact minimum, maximum, both orders
        run_seq(10'h023, 1'b1, 0);
        run_seq(10'h3ff, 1'b0, 0);
        run_seq(10'h155, 1'b1, 15);
        run_seq(10'h2aa, 1'b0, 8);
        run_seq(10'h001, 1'b1, 7);
        run_seq(10'h000, 1'b0, 15);

        for (int r = 0; r < 6; r++) begin
            run_seq(MODE_W'($urandom), 1'($urandom), int'($urandom % 16));
        end

        finish_run();
    end

endmodule